// File: doc/BRIEF.md
# Configuration Space Access Router

This block sits behind a flat memory-mapped window and steers configuration reads and writes to a grid of function slots. The grid is 32 device positions by 8 function positions by default. The block subtracts the window base from the requester's address. From the relative address it takes a device number, a function number and an 8-bit register offset. The access then goes to the addressed slot through an indexed slot bus. If the slot is empty, the block makes up the response itself.

The requester side is a single-outstanding valid/ready handshake. The requester raises `req_valid` with address, size, write flag and write data, and holds them until `req_ready` pulses. Sizes are counted in bytes, and only 1, 2 and 4 are legal. The slot side receives one cycle of `slot_en` in the cycle the request is accepted. The external slot mux answers combinationally with the selected function's data in that same cycle. Every accepted request completes after a fixed, parameterised number of extra cycles, whether it succeeded or raised an error.

Top module: `cfg_router`

## Requirements
- R1: After reset, `req_ready` and `slot_en` are both low until a request is presented.
- R2: For a request inside the window, `rel = req_addr - BASE`. The slot index is `{rel[15:11], rel[10:8]}`: the device number in the upper five bits and the function number in the lower three. `slot_offset` is `rel[7:0]`. The rest of `rel`, bits [23:16], has no effect on the decode.
- R3: A request with `req_addr < BASE` or `rel >= 0xFFFFFF` completes with `rsp_err` high and `rsp_rdata` zero, and `slot_en` stays low.
- R4: A `req_size` other than 1, 2 or 4 completes with `rsp_err` high and `rsp_rdata` zero, and `slot_en` stays low.
- R5: A read of a slot whose `slot_present` bit is low completes without error. It returns all ones in the low `req_size` bytes (0xFF, 0xFFFF or 0xFFFFFFFF) and zero above them.
- R6: A read of a present slot drives `slot_en` high with `slot_we` low and with the decoded index, offset and size. It returns `slot_rdata` masked to the low `req_size` bytes, with `rsp_err` low.
- R7: A write to an empty slot completes with `rsp_err` high and `rsp_rdata` zero, and `slot_en` stays low.
- R8: A write to a present slot drives `slot_en` and `slot_we` high and passes `req_wdata` to `slot_wdata`, with the decoded index, offset and size. It completes with `rsp_err` low and `rsp_rdata` zero.
- R9: `req_ready` is a one-cycle pulse. It arrives exactly `LATENCY+1` cycles after the clock edge that accepts the request, which is the cycle after acceptance when `LATENCY` is 0.
- R10: While a request is outstanding, `slot_en` stays low even when `req_valid` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion pulse |
| req_addr | input | ADDR_W | Absolute request address |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid with `req_ready` |
| rsp_err | output | 1 | Error flag, valid with `req_ready` |
| slot_en | output | 1 | Slot access strobe |
| slot_idx | output | IDX_W | Selected slot, {device, function} |
| slot_offset | output | 8 | Register offset within the function |
| slot_size | output | 3 | Access size in bytes |
| slot_we | output | 1 | Slot write enable |
| slot_wdata | output | 32 | Slot write data |
| slot_present | input | N_DEV*N_FUNC | Populated flag per slot |
| slot_rdata | input | 32 | Data from the selected slot, same cycle |

## Verification
The main instance is built with a non-zero base of 0x1000_0000 and `LATENCY` = 2. The non-zero base makes the base subtraction and the below-base rejection observable. The latency of 2 makes the hold-off of `slot_en` during busy cycles and the exact completion cycle measurable. A second instance with `LATENCY` = 0 covers the next-cycle completion corner. The slot population pattern (present unless the index is a multiple of 3) places empty and present slots at both ends of the grid. With that pattern, the window-edge address decodes to an empty slot while the high offset bits are discarded.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    localparam int DATA_W = 32;
    localparam int SZ_W   = 3;
    localparam int OFS_W  = 8;

    typedef enum logic [1:0] {
        ACC_RD_FWD  = 2'd0,
        ACC_WR_FWD  = 2'd1,
        ACC_RD_FILL = 2'd2,
        ACC_REJECT  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] data;
    } cfg_rsp_t;

    function automatic logic size_ok(input logic [SZ_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
    import cfgr_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE      = '0,
    parameter logic [ADDR_W-1:0]  WIN_BYTES = ADDR_W'(24'hFFFFFF),
    parameter int                 N_DEV     = 32,
    parameter int                 N_FUNC    = 8,
    localparam int                FN_W      = $clog2(N_FUNC),
    localparam int                DEV_W     = $clog2(N_DEV),
    localparam int                IDX_W     = DEV_W + FN_W,
    localparam int                N_SLOT    = N_DEV * N_FUNC
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    input  logic              write,
    input  logic [N_SLOT-1:0] present,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic [OFS_W-1:0]  ofs
);
    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic              filled;

    always_comb begin
        rel    = addr - BASE;
        in_win = (addr >= BASE) && (rel < WIN_BYTES);
        idx    = {rel[OFS_W+FN_W +: DEV_W], rel[OFS_W +: FN_W]};
        ofs    = rel[OFS_W-1:0];
        filled = present[idx];
        if (!in_win || !size_ok(size))
            kind = ACC_REJECT;
        else if (write)
            kind = filled ? ACC_WR_FWD : ACC_REJECT;
        else
            kind = filled ? ACC_RD_FWD : ACC_RD_FILL;
    end
endmodule

// File: rtl/cfgr_timer.sv
module cfgr_timer #(
    parameter int  LATENCY = 2,
    localparam int CNT_W   = (LATENCY < 1) ? 1 : $clog2(LATENCY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == CNT_W'(LATENCY));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt  <= cnt + 1'b1;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= CNT_W'(LATENCY)));
    assert_start_arms_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == '0));
endmodule

// File: rtl/cfgr_resp.sv
module cfgr_resp
    import cfgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  acc_kind_e         kind,
    input  logic [SZ_W-1:0]   size,
    input  logic [DATA_W-1:0] slot_rdata,
    output cfg_rsp_t          rsp
);
    cfg_rsp_t nxt;

    always_comb begin
        nxt = '0;
        case (kind)
            ACC_RD_FWD:  nxt.data = slot_rdata & size_mask(size);
            ACC_RD_FILL: nxt.data = size_mask(size);
            ACC_REJECT:  nxt.err  = 1'b1;
            default:     nxt      = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rsp <= '0;
        else if (capture) rsp <= nxt;
    end

    assert_err_no_data_R3: assert property (@(posedge clk) disable iff (rst)
        rsp.err |-> (rsp.data == '0));
endmodule

// File: rtl/cfg_router.sv
module cfg_router
    import cfgr_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE      = '0,
    parameter logic [ADDR_W-1:0]  WIN_BYTES = ADDR_W'(24'hFFFFFF),
    parameter int                 N_DEV     = 32,
    parameter int                 N_FUNC    = 8,
    parameter int                 LATENCY   = 2,
    localparam int                IDX_W     = $clog2(N_DEV) + $clog2(N_FUNC),
    localparam int                N_SLOT    = N_DEV * N_FUNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              slot_en,
    output logic [IDX_W-1:0]  slot_idx,
    output logic [7:0]        slot_offset,
    output logic [2:0]        slot_size,
    output logic              slot_we,
    output logic [31:0]       slot_wdata,
    input  logic [N_SLOT-1:0] slot_present,
    input  logic [31:0]       slot_rdata
);
    acc_kind_e        kind;
    logic             busy;
    logic             start;
    cfg_rsp_t         rsp;
    logic [SZ_W-1:0]  size_q;

    cfgr_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .WIN_BYTES(WIN_BYTES),
        .N_DEV(N_DEV), .N_FUNC(N_FUNC)
    ) u_decode (
        .addr(req_addr), .size(req_size), .write(req_write),
        .present(slot_present), .kind(kind), .idx(slot_idx), .ofs(slot_offset)
    );

    assign start = req_valid && !busy;

    cfgr_timer #(.LATENCY(LATENCY)) u_timer (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(req_ready)
    );

    cfgr_resp u_resp (
        .clk(clk), .rst(rst), .capture(start), .kind(kind),
        .size(req_size), .slot_rdata(slot_rdata), .rsp(rsp)
    );

    always_comb begin
        slot_en    = start && (kind == ACC_RD_FWD || kind == ACC_WR_FWD);
        slot_we    = start && (kind == ACC_WR_FWD);
        slot_size  = req_size;
        slot_wdata = req_wdata;
        rsp_rdata  = rsp.data;
        rsp_err    = rsp.err;
    end

    always_ff @(posedge clk) begin
        if (rst)        size_q <= '0;
        else if (start) size_q <= req_size;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !req_ready);
    assert_no_issue_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !slot_en);
    assert_wr_only_present_R7: assert property (@(posedge clk) disable iff (rst)
        (slot_en && slot_we) |-> slot_present[slot_idx]);
    assert_bad_size_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !size_ok(req_size)) |-> !slot_en);
    assert_byte_width_R5: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !rsp_err && size_q == 3'd1) |-> (rsp_rdata[31:8] == '0));
    assert_half_width_R5: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !rsp_err && size_q == 3'd2) |-> (rsp_rdata[31:16] == '0));
endmodule

// File: tb/cfg_router_tb.sv
`timescale 1ns/100ps
module cfg_router_tb;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int          LAT  = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst = 1'b1;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [2:0]  req_size = 3'd4;
    logic        req_ready, rsp_err, slot_en, slot_we;
    logic [31:0] rsp_rdata, slot_wdata, slot_rdata;
    logic [7:0]  slot_idx, slot_offset;
    logic [2:0]  slot_size;
    logic [255:0] present;

    for (genvar i = 0; i < 256; i++) begin : g_pres
        assign present[i] = (i % 3) != 0;
    end
    assign slot_rdata = {slot_idx ^ 8'hC0, slot_offset, 8'h5A, slot_idx};

    cfg_router #(.BASE(BASE), .LATENCY(LAT)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .slot_en(slot_en), .slot_idx(slot_idx), .slot_offset(slot_offset),
        .slot_size(slot_size), .slot_we(slot_we), .slot_wdata(slot_wdata),
        .slot_present(present), .slot_rdata(slot_rdata)
    );

    logic        vz = 1'b0, rz, ez, zen, zwe;
    logic [31:0] dz, zwd;
    logic [7:0]  zidx, zofs;
    logic [2:0]  zsz;
    cfg_router #(.BASE(BASE), .LATENCY(0)) u_dut_z (
        .clk(clk), .rst(rst), .req_valid(vz), .req_ready(rz),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_rdata(dz), .rsp_err(ez),
        .slot_en(zen), .slot_idx(zidx), .slot_offset(zofs),
        .slot_size(zsz), .slot_we(zwe), .slot_wdata(zwd),
        .slot_present({256{1'b1}}), .slot_rdata(32'h0)
    );

    int total = 0, bad = 0, wait_n = 0, cycles = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int dev, input int fn, input int ofs);
        return BASE + 32'((dev << 11) | (fn << 8) | ofs);
    endfunction

    function automatic logic [31:0] msk(input logic [2:0] sz);
        return (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic access(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                          input logic [31:0] wd, input logic [31:0] er, input logic ee,
                          input logic fwd, input logic [7:0] eidx, input string tag);
        @(negedge clk); #1;
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        exp_q.push_back({ee, er});
        tag_q.push_back(tag);
        #1;
        chk(slot_en == fwd, {tag, " slot_en"}, 32'(slot_en), 32'(fwd));
        if (fwd) begin
            chk(slot_idx == eidx, {tag, " R2 idx"}, 32'(slot_idx), 32'(eidx));
            chk(slot_offset == a[7:0], {tag, " R2 offset"}, 32'(slot_offset), 32'(a[7:0]));
            chk(slot_size == sz && slot_we == wr, {tag, " size/we"}, {28'd0, slot_we, slot_size}, {28'd0, wr, sz});
            if (wr) chk(slot_wdata == wd, {tag, " R8 wdata"}, slot_wdata, wd);
        end
        @(negedge clk);
        while (!req_ready) begin
            chk(!slot_en, {tag, " R10 busy slot_en"}, 32'(slot_en), 0);
            @(negedge clk);
        end
        #1 req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (req_valid) wait_n++;
            if (req_ready) begin
                logic [32:0] e;
                string t;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected ready", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rsp_rdata == e[31:0], {t, " rdata"}, rsp_rdata, e[31:0]);
                    chk(rsp_err == e[32], {t, " err"}, 32'(rsp_err), 32'(e[32]));
                    chk(wait_n == LAT + 1, {t, " R9 latency"}, 32'(wait_n), 32'(LAT + 1));
                end
                wait_n = 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!req_ready && !slot_en, "R1 reset quiet", {30'd0, req_ready, slot_en}, 0);

        // R6: present slot dev3 fn2 (index 26)
        access(mk(3, 2, 8'h10), 3'd4, 1'b0, 0, 32'hDA105A1A, 1'b0, 1'b1, 8'd26, "R6 word read");
        access(mk(3, 2, 8'h04), 3'd1, 1'b0, 0, 32'h1A, 1'b0, 1'b1, 8'd26, "R6 byte read");
        access(mk(0, 1, 8'h22), 3'd2, 1'b0, 0, 32'h5A01, 1'b0, 1'b1, 8'd1, "R6 half read");
        // R5: empty slots (index multiple of 3)
        access(mk(3, 0, 8'h08), 3'd2, 1'b0, 0, msk(3'd2), 1'b0, 1'b0, 0, "R5 empty half");
        access(mk(0, 0, 8'h00), 3'd4, 1'b0, 0, msk(3'd4), 1'b0, 1'b0, 0, "R5 empty word");
        access(mk(31, 7, 8'hFC), 3'd1, 1'b0, 0, msk(3'd1), 1'b0, 1'b0, 0, "R5 empty byte");
        // R8 / R7 writes
        access(mk(31, 6, 8'h3C), 3'd4, 1'b1, 32'hDEADBEEF, 0, 1'b0, 1'b1, 8'd254, "R8 write present");
        access(mk(5, 1, 8'h01), 3'd1, 1'b1, 32'h77, 0, 1'b0, 1'b1, 8'd41, "R8 byte write");
        access(mk(31, 7, 8'h00), 3'd4, 1'b1, 32'h1234, 0, 1'b1, 1'b0, 0, "R7 write empty");
        // R4 illegal sizes on a present slot
        access(mk(3, 2, 8'h00), 3'd3, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R4 size3");
        access(mk(3, 2, 8'h00), 3'd0, 1'b1, 32'h1, 0, 1'b1, 1'b0, 0, "R4 size0");
        // R3 window edges
        access(BASE - 1, 3'd4, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R3 below base");
        access(BASE + 32'hFFFFFF, 3'd1, 1'b0, 0, 0, 1'b1, 1'b0, 0, "R3 window end");
        // R2 last in-window byte decodes to dev31 fn7 (empty), high bits dropped
        access(BASE + 32'hFFFFFE, 3'd1, 1'b0, 0, msk(3'd1), 1'b0, 1'b0, 0, "R2 top of window");
        access(BASE + 32'h00AB_1A10, 3'd4, 1'b0, 0, 32'hDA105A1A, 1'b0, 1'b1, 8'd26, "R2 high bits ignored");

        // R9 zero latency instance
        @(negedge clk); #1;
        req_addr = mk(2, 2, 8'h00); req_size = 3'd4; req_write = 1'b0; vz = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!rz && n < 20);
        chk(n == 1, "R9 zero latency", 32'(n), 1);
        chk(dz == 0 && !ez, "R9 zero latency response", {ez, dz[30:0]}, 0);
        #1 vz = 1'b0;
        @(negedge clk);
        chk(!rz, "R9 single pulse", 32'(rz), 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all completed", 32'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule